// File: doc/BRIEF.md
# Redundant Modular Adder-Subtractor

This unit adds or subtracts two field elements modulo p = 2^224 - 2^96 + 1. Operands and results are held in a loose form that allows any value in [0, 2^224), so numbers between p and 2^224 - 1 are legal on both sides. The unit never compares a value against p. Any weight that lands above bit 223 is folded back into the low 224 bits, using the fact that 2^224 is congruent to 2^96 - 1 modulo p.

For subtraction the unit first adds 2p to the minuend, so the intermediate value can never go negative. The count of 2^224 units above bit 223 then selects a fold constant t·(2^96 - 1), built limb by limb from t. The fold is applied twice, and the second pass is always computed. Because of that, latency is one clock for every operand pair. A caller can chain results straight back in as operands, and a canonical value in [0, p) only has to be produced once, at the very end of a computation.

Top module: `modadd_p224`

## Requirements
- R1: With `op_sub` = 0 the unit adds: `result` is congruent to `opa` + `opb` modulo p.
- R2: With `op_sub` = 1 the unit subtracts: `result` is congruent to `opa` - `opb` modulo p.
- R3: Any operand in [0, 2^224) is accepted, including p and 2^224 - 1. The result always lies in [0, 2^224).
- R4: Exact add value: let s = a + b, h = floor(s / 2^224) and r = (s mod 2^224) + h·(2^96 - 1). If r < 2^224, the result is r. Otherwise the result is r - 2^224 + 2^96 - 1.
- R5: Exact subtract value: the same fold applies with s = 2p + a - b. Here h is 0, 1 or 2, and it never reaches 3.
- R6: When the first fold carries past bit 223, the second fold removes the carry without producing a new one. For example, 2^224 - 1 added to itself gives 2^97 - 4.
- R7: `out_valid` is high in exactly the cycle after a cycle in which `in_valid` was high, and `result` is updated from that input. Latency does not depend on the data.
- R8: While `in_valid` is low, `result` holds its last value.
- R9: During and after reset (`rst_n` low, active-low), `out_valid` is 0 and `result` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands and operation are presented this cycle |
| op_sub | input | 1 | 0 = add, 1 = subtract (opa - opb) |
| opa | input | 224 | First operand, any value below 2^224 |
| opb | input | 224 | Second operand, any value below 2^224 |
| out_valid | output | 1 | Result register holds a new result |
| result | output | 224 | Sum or difference modulo p, in [0, 2^224) |

## Verification
A wrong fold constant or a wrong carry count would show as a value that is not congruent to the true sum or difference. A wrong limb in the constant, or a missed second fold, would produce a different exact value even when the residue looks plausible. Either fault appears on `result` in the single cycle after the operands are accepted, so every vector is compared against both the exact value and the residue modulo p. A broken valid pipeline or a broken hold shows one cycle later, either as a stray or missing `out_valid` or as a result that moves while the input is idle.

// File: rtl/modadd_p224.sv
module modadd_p224 (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic         op_sub,
  input  logic [223:0] opa,
  input  logic [223:0] opb,
  output logic         out_valid,
  output logic [223:0] result
);

  localparam int W  = 224;
  localparam int WX = W + 2;
  localparam logic [W-1:0]  P_MOD  = {{4{32'hFFFF_FFFF}}, 32'h0, 32'h0, 32'h1};
  localparam logic [WX-1:0] TWO_P  = {1'b0, P_MOD, 1'b0};

  function automatic logic [W-1:0] fold_k(input logic [1:0] t);
    logic [W-1:0] k;
    k = '0;
    k[31:0] = 32'h0 - {30'h0, t};
    if (t != 2'd0) begin
      k[63:32] = 32'hFFFF_FFFF;
      k[95:64] = 32'hFFFF_FFFF;
      k[127:96] = {30'h0, t} - 32'd1;
    end
    return k;
  endfunction

  logic [WX-1:0] pre_add, pre_sub, pre;
  logic [1:0]    hi;
  logic [W:0]    f1, f2;

  assign pre_add = {2'b00, opa} + {2'b00, opb};
  assign pre_sub = TWO_P + {2'b00, opa} - {2'b00, opb};
  assign pre     = op_sub ? pre_sub : pre_add;
  assign hi      = pre[WX-1:W];
  assign f1      = {1'b0, pre[W-1:0]} + {1'b0, fold_k(hi)};
  assign f2      = {1'b0, f1[W-1:0]} + {1'b0, fold_k({1'b0, f1[W]})};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= f2[W-1:0];
    end
  end

  a_r1_add_carry_small: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !op_sub) |-> !hi[1]);

  a_r5_sub_carry_range: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sub) |-> (hi != 2'b11));

  a_r6_second_fold_clean: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> !f2[W]);

  a_r7_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r7_no_stray_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));

endmodule

// File: tb/tb_modadd_p224.sv
`timescale 1ns/1ps
module tb_modadd_p224;

  localparam logic [223:0] PM = {{4{32'hFFFF_FFFF}}, 32'h0, 32'h0, 32'h1};
  localparam logic [223:0] MX = '1;
  localparam logic [223:0] RA = 224'h0123456789ABCDEF_FEDCBA9876543210_0F1E2D3C4B5A6978_8796A5B4;
  localparam logic [223:0] RB = 224'hDEADBEEF_CAFEF00D_12345678_9ABCDEF0_0FEDCBA9_87654321_55AA55AA;
  localparam int NV = 14;
  localparam logic         V_OP [NV] = '{0, 0, 0, 0, 0, 0, 1, 1, 1, 1, 1, 1, 0, 1};
  localparam logic [223:0] V_A  [NV] = '{224'd0, 224'd1, PM, MX, MX, PM, 224'd5, 224'd0, MX, 224'd0, PM, 224'd0, RA, RB};
  localparam logic [223:0] V_B  [NV] = '{224'd0, 224'd2, 224'd1, 224'd1, MX, PM, 224'd3, MX, 224'd0, 224'd0, 224'd0, PM, RB, RA};

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, op_sub = 1'b0;
  logic [223:0] opa = '0, opb = '0;
  logic out_valid;
  logic [223:0] result;
  int nvec = 0, nfail = 0;

  always #4 clk = ~clk;

  modadd_p224 dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sub(op_sub),
                   .opa(opa), .opb(opb), .out_valid(out_valid), .result(result));

  function automatic logic [223:0] exact(input logic op, input logic [223:0] a, input logic [223:0] b);
    logic [226:0] s, r, f;
    f = (227'd1 << 96) - 227'd1;
    s = op ? ({3'b0, PM} << 1) + {3'b0, a} - {3'b0, b} : {3'b0, a} + {3'b0, b};
    r = {3'b0, s[223:0]} + {224'd0, s[226:224]} * f;
    if (r[224]) r = {3'b0, r[223:0]} + f;
    return r[223:0];
  endfunction

  function automatic logic [255:0] residue(input logic op, input logic [223:0] a, input logic [223:0] b);
    logic [255:0] p, am, bm;
    p = {32'd0, PM};
    am = {32'd0, a} % p;
    bm = {32'd0, b} % p;
    return op ? (am + p - bm) % p : (am + bm) % p;
  endfunction

  task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic op, input logic [223:0] a, input logic [223:0] b);
    @(negedge clk);
    in_valid = 1'b1; op_sub = op; opa = a; opb = b;
    @(negedge clk);
    in_valid = 1'b0;
    check("R7 valid after accept", {255'd0, out_valid}, 256'd1);
    check(op ? "R5 exact difference" : "R4 exact sum", {32'd0, result}, {32'd0, exact(op, a, b)});
    check(op ? "R2 difference mod p" : "R1 sum mod p", {32'd0, result} % {32'd0, PM}, residue(op, a, b));
  endtask

  initial begin
    #(8 * 200000);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    logic [223:0] held;
    repeat (3) @(negedge clk);
    check("R9 reset valid", {255'd0, out_valid}, 256'd0);
    check("R9 reset result", {32'd0, result}, 256'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 idle after reset", {255'd0, out_valid}, 256'd0);

    for (int i = 0; i < NV; i++) apply(V_OP[i], V_A[i], V_B[i]);

    apply(1'b0, MX, MX);
    check("R6 double fold value", {32'd0, result}, {32'd0, (224'd1 << 97) - 224'd4});
    apply(1'b0, MX, 224'd1);
    check("R3 wrap from top value", {32'd0, result}, {32'd0, (224'd1 << 96) - 224'd1});
    apply(1'b1, 224'd5, 224'd3);
    check("R3 op select subtract", {32'd0, result}, {32'd0, PM + 224'd2});

    held = result;
    opa = RA; opb = RB; op_sub = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 hold while idle", {32'd0, result}, {32'd0, held});
    check("R7 no valid while idle", {255'd0, out_valid}, 256'd0);

    @(negedge clk);
    in_valid = 1'b1; op_sub = 1'b0; opa = 224'd7; opb = 224'd8;
    @(negedge clk);
    op_sub = 1'b1; opa = 224'd7; opb = 224'd8;
    check("R7 back-to-back first", {32'd0, result}, 256'd15);
    @(negedge clk);
    in_valid = 1'b0;
    check("R7 back-to-back second", {32'd0, result}, {32'd0, exact(1'b1, 224'd7, 224'd8)});
    check("R2 back-to-back mod p", {32'd0, result} % {32'd0, PM}, {32'd0, PM - 224'd1});

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

endmodule